// File: doc/BRIEF.md
# Release-On-Acknowledge Bus Interrupter

This block raises one of seven active-low interrupt request lines on a shared backplane. Software picks the line by writing a 3-bit level into a request register. Level 0 raises nothing. Levels 1 to 7 pull down the line of that number. Software also loads an 8-bit status/ID byte, which the block hands out when its request is serviced.

When the bus master runs an interrupt acknowledge cycle, it presents the level it is serving, and an enable arrives down the daisy chain. If that level matches the pending request, the block claims the cycle. It drives the status/ID byte for one cycle, pulses a data-acknowledge, and clears its own request register, which releases the line with no software action. A block that does not claim the cycle passes the daisy-chain enable on to the next device.

Top module: `roak_interrupter`

## Requirements
- R1: After a synchronous reset: the level register reads 0, the ID register reads 0, every `irq_n` bit is 1 and `dtack` is 0.
- R2: One cycle after software writes a level L from 1 to 7 (`cpu_sel`=0, level in `cpu_wdata[2:0]`), `irq_n[L-1]` is 0 and every other `irq_n` bit is 1. At no time is more than one `irq_n` bit 0.
- R3: One cycle after software writes level 0, every `irq_n` bit is 1.
- R4: The read port returns a value selected by `cpu_sel`, with no clock delay. `cpu_sel`=0 returns the level in bits 2:0, with 0 in bits 7:3. `cpu_sel`=1 returns the ID byte.
- R5: The block claims an acknowledge when all of the following hold at a clock edge: `iack`=1, `iack_in`=1, the level is nonzero and `iack_lvl` equals the level. In the next cycle `dtack` is 1, `ack_data` holds the ID byte, the level reads 0 and every `irq_n` bit is 1.
- R6: `iack_out` equals `iack & iack_in` whenever the block neither meets the claim condition nor holds a claim. An acknowledge at another level, or one without `iack_in`, leaves the level and the IRQ lines unchanged and produces no `dtack`.
- R7: `iack_out` is 0 while the claim condition holds. It also stays 0 after a claim until `iack` returns to 0.
- R8: If a level write and a claim happen at the same clock edge, the level register takes the written value. `dtack` still pulses.
- R9: `dtack` is 1 for exactly one cycle per claim, even if `iack` stays high.
- R10: `ack_data` is 0 in every cycle where `dtack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel | input | 1 | Register select: 0 selects the level register, 1 selects the ID register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the selected register |
| irq_n | output | 7 | Active-low request lines; bit i is level i+1 |
| iack | input | 1 | An interrupt acknowledge cycle is in progress |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_in | input | 1 | Daisy-chain enable from the previous device |
| iack_out | output | 1 | Daisy-chain enable passed to the next device |
| dtack | output | 1 | One-cycle data-acknowledge pulse on a claim |
| ack_data | output | 8 | Status/ID byte during `dtack`, otherwise 0 |

## Verification
The case that is hardest to reach from the ports is a software write landing on the same clock edge as a claim. The bench produces it by asserting the write and the matching acknowledge together, with a different new level, and then checks that the new level is kept and the pulse still appears. It also covers the claim-hold window: `iack` is kept high after the claim so that `iack_out` and `dtack` can be checked once the level register has already cleared. In addition, the bench sweeps every pending level against every acknowledged level, with the daisy-chain enable both on and off.

// File: rtl/roak_pkg.sv
package roak_pkg;
    localparam int LVL_W = 3;
    localparam int ID_W  = 8;
    localparam int NLEV  = (1 << LVL_W) - 1;

    typedef enum logic {
        SEL_LVL = 1'b0,
        SEL_ID  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             chain_in;
        logic [LVL_W-1:0] lvl;
    } ack_cycle_t;

    function automatic logic [NLEV-1:0] lvl_to_irq_n(input logic [LVL_W-1:0] l);
        logic [NLEV-1:0] r;
        r = '1;
        if (l != '0) r[l - 1'b1] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/roak_regs.sv
module roak_regs
    import roak_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int IW = ID_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  reg_sel_e      sel,
    input  logic [IW-1:0] wdata,
    input  logic          clr,
    output logic [LW-1:0] lvl,
    output logic [IW-1:0] id
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= '0;
            id  <= '0;
        end else begin
            if (wr && sel == SEL_ID) id <= wdata;
            // a software write wins over the self-clear
            if (wr && sel == SEL_LVL) lvl <= wdata[LW-1:0];
            else if (clr)             lvl <= '0;
        end
    end
endmodule

// File: rtl/roak_ack.sv
module roak_ack
    import roak_pkg::*;
#(
    parameter int IW = ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ack_cycle_t       cyc,
    input  logic [LVL_W-1:0] lvl,
    input  logic [IW-1:0]    id,
    output logic             clr,
    output logic             chain_out,
    output logic             dtack,
    output logic [IW-1:0]    ack_data
);
    logic hit, owned;

    always_comb begin
        hit       = cyc.valid && cyc.chain_in && (lvl != '0) && (cyc.lvl == lvl);
        clr       = hit && !owned;
        chain_out = cyc.valid && cyc.chain_in && !hit && !owned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned    <= 1'b0;
            dtack    <= 1'b0;
            ack_data <= '0;
        end else begin
            owned    <= cyc.valid ? (owned || hit) : 1'b0;
            dtack    <= clr;
            ack_data <= clr ? id : '0;
        end
    end
endmodule

// File: rtl/roak_irq_drv.sv
module roak_irq_drv
    import roak_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output logic [NLEV-1:0]  irq_n
);
    for (genvar i = 0; i < NLEV; i++) begin : g_line
        assign irq_n[i] = (lvl != LVL_W'(i + 1));
    end
endmodule

// File: rtl/roak_interrupter.sv
module roak_interrupter
    import roak_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic             cpu_sel,
    input  logic [ID_W-1:0]  cpu_wdata,
    output logic [ID_W-1:0]  cpu_rdata,
    output logic [NLEV-1:0]  irq_n,
    input  logic             iack,
    input  logic [LVL_W-1:0] iack_lvl,
    input  logic             iack_in,
    output logic             iack_out,
    output logic             dtack,
    output logic [ID_W-1:0]  ack_data
);
    logic [LVL_W-1:0] lvl;
    logic [ID_W-1:0]  id;
    logic             clr;
    reg_sel_e         sel;
    ack_cycle_t       cyc;

    assign sel = reg_sel_e'(cpu_sel);
    assign cyc = '{valid: iack, chain_in: iack_in, lvl: iack_lvl};

    roak_regs #(.LW(LVL_W), .IW(ID_W)) u_regs (
        .clk(clk), .rst(rst), .wr(cpu_wr), .sel(sel), .wdata(cpu_wdata),
        .clr(clr), .lvl(lvl), .id(id)
    );

    roak_ack #(.IW(ID_W)) u_ack (
        .clk(clk), .rst(rst), .cyc(cyc), .lvl(lvl), .id(id), .clr(clr),
        .chain_out(iack_out), .dtack(dtack), .ack_data(ack_data)
    );

    roak_irq_drv u_drv (.lvl(lvl), .irq_n(irq_n));

    always_comb begin
        if (sel == SEL_ID) cpu_rdata = id;
        else               cpu_rdata = {{(ID_W-LVL_W){1'b0}}, lvl};
    end
endmodule

// File: rtl/roak_interrupter_chk.sv
module roak_interrupter_chk
    import roak_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cpu_wr,
    input logic            cpu_sel,
    input logic [NLEV-1:0] irq_n,
    input logic            iack,
    input logic            iack_out,
    input logic            dtack,
    input logic [ID_W-1:0] ack_data
);
    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (&irq_n && !dtack)); // R1
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst) $onehot0(~irq_n)); // R2
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (dtack && !$past(cpu_wr && cpu_sel == SEL_LVL)) |-> &irq_n); // R5
    AST_NO_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst) !iack |-> !iack_out); // R6
    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (rst) (dtack && iack) |-> !iack_out); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) dtack |=> !dtack); // R9
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst) !dtack |-> (ack_data == '0)); // R10
endmodule

bind roak_interrupter roak_interrupter_chk u_chk (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .irq_n(irq_n),
    .iack(iack), .iack_out(iack_out), .dtack(dtack), .ack_data(ack_data)
);

// File: tb/roak_interrupter_test.sv
module roak_interrupter_test;
    import roak_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_wr = 1'b0;
    logic             cpu_sel = 1'b0;
    logic [ID_W-1:0]  cpu_wdata = '0;
    logic [ID_W-1:0]  cpu_rdata;
    logic [NLEV-1:0]  irq_n;
    logic             iack = 1'b0;
    logic [LVL_W-1:0] iack_lvl = '0;
    logic             iack_in = 1'b0;
    logic             iack_out;
    logic             dtack;
    logic [ID_W-1:0]  ack_data;

    int runs = 0;
    int fails = 0;

    always #10 clk = ~clk;

    roak_interrupter uut (.*);

    function automatic logic [NLEV-1:0] exp_irq(input int l);
        logic [NLEV-1:0] r;
        r = '1;
        if (l != 0) r = r & ~(NLEV'(1) << (l - 1));
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic s, input logic [ID_W-1:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic read_lvl(input string req, input int exp);
        cpu_sel = 1'b0; #1;
        check(req, 32'(cpu_rdata), 32'(exp));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq_n), 32'(exp_irq(0)));
        check("R1 dtack", 32'(dtack), 0);
        read_lvl("R1 lvl", 0);
        cpu_sel = 1'b1; #1;
        check("R1 id", 32'(cpu_rdata), 0);

        // R2/R3/R4 level sweep
        for (int l = 0; l <= NLEV; l++) begin
            wr_reg(1'b0, ID_W'(l) | 8'hF8);
            check(l == 0 ? "R3 irq" : "R2 irq", 32'(irq_n), 32'(exp_irq(l)));
            read_lvl("R4 lvl read", l);
        end
        wr_reg(1'b0, 8'h00);
        check("R3 irq clear", 32'(irq_n), 32'(exp_irq(0)));
        wr_reg(1'b1, 8'hA5);
        cpu_sel = 1'b1; #1;
        check("R4 id read", 32'(cpu_rdata), 32'hA5);

        // R5/R6/R7/R9/R10 acknowledge sweep
        for (int l = 1; l <= NLEV; l++) begin
            for (int a = 1; a <= NLEV; a++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [ID_W-1:0] idv;
                    bit hit;
                    idv = ID_W'(l * 16 + a * 2 + c);
                    hit = (c == 1) && (a == l);
                    wr_reg(1'b1, idv);
                    wr_reg(1'b0, ID_W'(l));
                    iack = 1'b1; iack_lvl = LVL_W'(a); iack_in = c[0]; #1;
                    check(hit ? "R7 chain blocked" : "R6 chain pass", 32'(iack_out), 32'(c == 1 && !hit));
                    check("R10 idle data", 32'(ack_data), 0);
                    @(negedge clk);
                    check(hit ? "R5 dtack" : "R6 no dtack", 32'(dtack), 32'(hit));
                    check(hit ? "R5 data" : "R10 data", 32'(ack_data), hit ? 32'(idv) : 0);
                    check(hit ? "R5 release" : "R6 irq held", 32'(irq_n), 32'(exp_irq(hit ? 0 : l)));
                    read_lvl(hit ? "R5 lvl clear" : "R6 lvl kept", hit ? 0 : l);
                    if (hit) check("R7 hold blocked", 32'(iack_out), 0);
                    @(negedge clk);
                    check("R9 single pulse", 32'(dtack), 0);
                    if (hit) check("R7 still blocked", 32'(iack_out), 0);
                    iack = 1'b0; iack_in = 1'b0;
                    @(negedge clk);
                end
            end
        end

        // R8 write coincident with claim
        wr_reg(1'b1, 8'h3C);
        wr_reg(1'b0, 8'd3);
        @(negedge clk);
        iack = 1'b1; iack_lvl = 3'd3; iack_in = 1'b1;
        cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 8'd5;
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R8 dtack", 32'(dtack), 1);
        check("R8 data", 32'(ack_data), 32'h3C);
        check("R8 irq", 32'(irq_n), 32'(exp_irq(5)));
        read_lvl("R8 lvl kept", 5);
        iack = 1'b0; iack_in = 1'b0;
        @(negedge clk);

        // R1 reset clears a pending level
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", 32'(irq_n), 32'(exp_irq(0)));
        read_lvl("R1 lvl after reset", 0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule